// File: doc/BRIEF.md
# Load/Store Lane Alignment and Extension Unit

This unit sits between a 32-bit core and a word-organised data memory with one cycle of read latency. For each request it adds a sign-extended 16-bit displacement to a base register value to form a byte address. It checks that the address suits the access width of one, two or four bytes. It then presents a word address, per-byte write strobes and lane-placed store data to the memory. For loads, it takes the addressed bytes out of the returned word and widens them to a full 32-bit register value, filling the upper bits with copies of the sign bit or with zeros.

An input selects the byte order for each request. In little-endian order, byte offset 0 is bits 7:0 of the memory word. In big-endian order, byte offset 0 is bits 31:24, and halfwords occupy lanes the same mirrored way. A misaligned request raises a fault output in the same cycle and does not touch memory. A load that is accepted returns its value together with a valid strobe one cycle later.

Top module: `ldst_lane_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits. For an accepted request, `mem_addr` equals bits 31:2 of that sum.
- R2: A request faults when the size is halfword and address bit 0 is 1, or when the size is word and address bits 1:0 are not 00. In the request cycle, a faulting request raises `align_fault` and holds `mem_en`, `mem_we` and all of `mem_be` low. Memory contents stay unchanged, and no `ld_valid` follows. Byte requests never fault.
- R3: `req_size` encoding: 0 selects byte, 1 selects halfword, 2 selects word, and 3 is handled exactly as a word.
- R4: Byte strobes cover the addressed bytes. In little-endian mode, the lowest strobed lane equals the address offset (bits 1:0). In big-endian mode it is 3 minus the offset for bytes and 2 minus the offset for halfwords. A word strobes all four lanes in both modes.
- R5: For stores, each strobed lane carries the source byte whose index is that lane minus the lowest strobed lane. Bits of `req_wdata` above the access width have no effect on memory.
- R6: An accepted, non-faulting load raises `ld_valid` for exactly one cycle, in the cycle after the request, with the result on `ld_data`. Stores, faults and idle cycles give `ld_valid` = 0 and `ld_data` = 0.
- R7: A byte or halfword load with `req_unsigned` = 0 copies the datum's top bit into all upper result bits.
- R8: A byte or halfword load with `req_unsigned` = 1 returns zeros in all upper result bits.
- R9: Load extraction uses the same lane mapping as R4. A word load returns the memory word unchanged in both byte orders.
- R10: While reset is asserted, and until two clock edges after it is released, no request is accepted: `mem_en`, `align_fault` and `ld_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (R3) |
| req_unsigned | input | 1 | Zero-fill narrow loads |
| req_big_endian | input | 1 | 1 = big-endian lane order |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Per-lane byte strobes |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Read word, one cycle after `mem_en` |
| align_fault | output | 1 | Misaligned request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The hardest case to reach from the ports is a narrow load whose bytes land in a non-trivial lane under big-endian order. The load must follow a store to the same word in the very next cycle, so the returned lane has to reflect the new write and not stale contents. The stimulus writes words with distinctive byte values and with top bits set in chosen lanes. It then sweeps every offset, size, signedness and byte order directly after the store. A long randomised mix of stores, loads, misaligned requests and idle gaps follows, all checked against a behavioural shadow memory kept in the bench.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int NBYTES = 4
) (
  input  logic [ADDR_W-1:0]        base,
  input  logic [DISP_W-1:0]        disp,
  input  acc_size_e                size,
  input  logic                     big_endian,
  output logic [ADDR_W-$clog2(NBYTES)-1:0] word_addr,
  output logic [$clog2(NBYTES)-1:0] lane,
  output logic [NBYTES-1:0]        lane_mask,
  output logic                     misaligned
);
  localparam int OFF_W = $clog2(NBYTES);
  localparam int NB_W  = OFF_W + 1;

  logic [ADDR_W-1:0] ea;
  logic [OFF_W-1:0]  off;
  logic [NB_W-1:0]   nb;
  logic [OFF_W-1:0]  algn_mask;
  logic [NB_W-1:0]   be_lane;

  always_comb begin
    ea = base + {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    off = ea[OFF_W-1:0];
    unique case (size)
      SZ_BYTE: nb = NB_W'(1);
      SZ_HALF: nb = NB_W'(2);
      default: nb = NB_W'(NBYTES);
    endcase
    algn_mask  = OFF_W'(nb - NB_W'(1));
    misaligned = |(off & algn_mask);
    be_lane    = NB_W'(NBYTES) - nb - {1'b0, off};
    lane       = big_endian ? be_lane[OFF_W-1:0] : off;
    lane_mask  = NBYTES'((NB_W'(1) << nb) - NB_W'(1));
    word_addr  = ea[ADDR_W-1:OFF_W];
  end

endmodule

// File: rtl/ldst_store_steer.sv
module ldst_store_steer
  import ldst_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic                      enable,
  input  acc_size_e                 size,
  input  logic [$clog2(NBYTES)-1:0] lane,
  input  logic [NBYTES-1:0]         lane_mask,
  input  logic [8*NBYTES-1:0]       wdata,
  output logic [NBYTES-1:0]         be,
  output logic [8*NBYTES-1:0]       wdata_out
);
  always_comb begin
    be = enable ? NBYTES'(lane_mask << lane) : '0;
  end

  for (genvar gl = 0; gl < NBYTES; gl++) begin : gen_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: wdata_out[8*gl +: 8] = wdata[7:0];
        SZ_HALF: wdata_out[8*gl +: 8] = wdata[8*(gl % 2) +: 8];
        default: wdata_out[8*gl +: 8] = wdata[8*gl +: 8];
      endcase
    end
  end

endmodule

// File: rtl/ldst_load_extend.sv
module ldst_load_extend
  import ldst_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid,
  input  acc_size_e                 size,
  input  logic [$clog2(NBYTES)-1:0] lane,
  input  logic                      is_unsigned,
  input  logic [8*NBYTES-1:0]       rdata,
  output logic [8*NBYTES-1:0]       data
);
  localparam int DATA_W = 8 * NBYTES;

  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] ext;

  always_comb begin
    shifted = rdata >> {lane, 3'b000};
    unique case (size)
      SZ_BYTE: ext = {{(DATA_W-8){~is_unsigned & shifted[7]}}, shifted[7:0]};
      SZ_HALF: ext = {{(DATA_W-16){~is_unsigned & shifted[15]}}, shifted[15:0]};
      default: ext = shifted;
    endcase
    data = valid ? ext : '0;
  end

  // R8: unsigned narrow loads leave the upper bits clear
  a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_unsigned && size == SZ_BYTE) |-> (data[DATA_W-1:8] == '0));

  // R7: signed halfword loads replicate bit 15 upwards
  a_r7_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !is_unsigned && size == SZ_HALF) |->
      (data[DATA_W-1:16] == {(DATA_W-16){data[15]}}));

endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int NBYTES = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic                                 req_store,
  input  logic [1:0]                           req_size,
  input  logic                                 req_unsigned,
  input  logic                                 req_big_endian,
  input  logic [ADDR_W-1:0]                    req_base,
  input  logic [DISP_W-1:0]                    req_disp,
  input  logic [8*NBYTES-1:0]                  req_wdata,
  output logic                                 mem_en,
  output logic                                 mem_we,
  output logic [ADDR_W-$clog2(NBYTES)-1:0]     mem_addr,
  output logic [NBYTES-1:0]                    mem_be,
  output logic [8*NBYTES-1:0]                  mem_wdata,
  input  logic [8*NBYTES-1:0]                  mem_rdata,
  output logic                                 align_fault,
  output logic                                 ld_valid,
  output logic [8*NBYTES-1:0]                  ld_data
);
  localparam int OFF_W = $clog2(NBYTES);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  acc_size_e        size_e;
  logic [OFF_W-1:0] lane;
  logic [NBYTES-1:0] lane_mask;
  logic             misaligned;
  logic             accepted;
  logic             go;

  assign size_e = acc_size_e'(req_size);

  ldst_addr_gen #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .NBYTES(NBYTES)
  ) u_agen (
    .base      (req_base),
    .disp      (req_disp),
    .size      (size_e),
    .big_endian(req_big_endian),
    .word_addr (mem_addr),
    .lane      (lane),
    .lane_mask (lane_mask),
    .misaligned(misaligned)
  );

  always_comb begin
    accepted    = req_valid & rst_ok;
    go          = accepted & ~misaligned;
    align_fault = accepted & misaligned;
    mem_en      = go;
    mem_we      = go & req_store;
  end

  ldst_store_steer #(.NBYTES(NBYTES)) u_steer (
    .enable   (go),
    .size     (size_e),
    .lane     (lane),
    .lane_mask(lane_mask),
    .wdata    (req_wdata),
    .be       (mem_be),
    .wdata_out(mem_wdata)
  );

  // load context held across the memory latency
  logic             ldp_q, ldp_d;
  acc_size_e        lsz_q, lsz_d;
  logic [OFF_W-1:0] llane_q, llane_d;
  logic             luns_q, luns_d;
  logic             ctx_en;

  always_comb begin
    ldp_d   = go & ~req_store;
    ctx_en  = ldp_d;
    lsz_d   = ctx_en ? size_e       : lsz_q;
    llane_d = ctx_en ? lane         : llane_q;
    luns_d  = ctx_en ? req_unsigned : luns_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldp_q   <= 1'b0;
      lsz_q   <= SZ_WORD;
      llane_q <= '0;
      luns_q  <= 1'b0;
    end else begin
      ldp_q   <= ldp_d;
      lsz_q   <= lsz_d;
      llane_q <= llane_d;
      luns_q  <= luns_d;
    end
  end

  assign ld_valid = ldp_q;

  ldst_load_extend #(.NBYTES(NBYTES)) u_ext (
    .clk        (clk),
    .rst_n      (rst_ok),
    .valid      (ldp_q),
    .size       (lsz_q),
    .lane       (llane_q),
    .is_unsigned(luns_q),
    .rdata      (mem_rdata),
    .data       (ld_data)
  );

  // R2: a fault leaves the memory interface quiet
  a_r2_fault_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    align_fault |-> (!mem_en && !mem_we && mem_be == '0));

  // R2: byte requests never fault
  a_r2_byte_never_faults: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_size == 2'd0) |-> !align_fault);

  // R4: strobe count matches the access width
  a_r4_be_count: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_en |-> ($countones(mem_be) ==
      ((req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : NBYTES)));

  // R6: load result only after an accepted read
  a_r6_ld_follows_read: assert property (@(posedge clk) disable iff (!rst_ok)
    ld_valid |-> $past(mem_en && !mem_we));

  // R6: a store is never followed by a load result
  a_r6_store_no_result: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_en && mem_we) |=> !ld_valid);

endmodule

// File: tb/ldst_lane_unit_bench.sv
`timescale 1ns/1ps
module ldst_lane_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_unsigned, req_big_endian;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wdata;
  logic [15:0] req_disp;
  logic        mem_en, mem_we, align_fault, ld_valid;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata, ld_data;

  always #2.5 clk = ~clk;

  ldst_lane_unit u_ldst_lane_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
    .req_unsigned(req_unsigned), .req_big_endian(req_big_endian),
    .req_base(req_base), .req_disp(req_disp), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .align_fault(align_fault), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // memory attached to the design
  logic [31:0] dmem [256];
  // shadow memory kept from request semantics only
  logic [31:0] rmem [256];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) dmem[mem_addr[7:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= dmem[mem_addr[7:0]];
      end
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit exp_ldv = 0;
  logic [31:0] exp_ld = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit st, input logic [1:0] sz,
                      input bit uns, input bit bend, input logic [31:0] base,
                      input logic [15:0] disp, input logic [31:0] wd);
    logic [31:0] ea, w;
    int n, off, lane;
    bit fault;
    logic [3:0] ebe;
    @(negedge clk);
    req_valid = v; req_store = st; req_size = sz; req_unsigned = uns;
    req_big_endian = bend; req_base = base; req_disp = disp; req_wdata = wd;
    #1;
    // R6: result of previous cycle's request
    chk("R6 ld_valid", {31'b0, ld_valid}, {31'b0, exp_ldv});
    if (exp_ldv) chk("R7/R8/R9 ld_data", ld_data, exp_ld);
    else         chk("R6 ld_data idle zero", ld_data, 32'h0);
    ea = base + {{16{disp[15]}}, disp};
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;   // R3
    off = int'(ea[1:0]);
    fault = (off % n) != 0;
    lane = bend ? (4 - n - off) : off;
    ebe = fault ? 4'b0 : 4'(((1 << n) - 1) << lane);
    exp_ldv = 0;
    if (!v) begin
      chk("R6 idle mem_en", {31'b0, mem_en}, 32'h0);
      chk("R2 idle align_fault", {31'b0, align_fault}, 32'h0);
    end else begin
      chk("R2 align_fault", {31'b0, align_fault}, {31'b0, fault});
      chk("R2 mem_en", {31'b0, mem_en}, {31'b0, !fault});
      chk("R2 mem_we", {31'b0, mem_we}, {31'b0, st && !fault});
      chk("R4 mem_be", {28'b0, mem_be}, {28'b0, ebe});
      if (!fault) begin
        chk("R1 mem_addr", {2'b0, mem_addr}, {2'b0, ea[31:2]});
        if (st) begin
          for (int l = 0; l < 4; l++)
            if (ebe[l]) begin
              chk("R5 lane data", {24'b0, mem_wdata[8*l +: 8]},
                  {24'b0, wd[8*(l-lane) +: 8]});
              rmem[ea[9:2]][8*l +: 8] = wd[8*(l-lane) +: 8];
            end
        end else begin
          w = rmem[ea[9:2]] >> (8*lane);
          if (n == 1)      w = {{24{!uns & w[7]}}, w[7:0]};
          else if (n == 2) w = {{16{!uns & w[15]}}, w[15:0]};
          exp_ld = w;
          exp_ldv = 1;
        end
      end
    end
  endtask

  task automatic idle();
    step(0, 0, 2'd0, 0, 0, 32'h0, 16'h0, 32'h0);
  endtask

  // load-back check of a whole word in little-endian order
  task automatic peek(input logic [31:0] addr);
    step(1, 0, 2'd2, 0, 0, addr, 16'h0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      dmem[i] = 32'h5A00_0000 ^ (i * 32'h0103_0507);
      rmem[i] = dmem[i];
    end
    mem_rdata = '0;
    req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
    req_big_endian = 0; req_base = 0; req_disp = 0; req_wdata = 0;
    rst_n = 0;
    // R10: a request during reset is not accepted
    repeat (2) @(negedge clk);
    req_valid = 1;
    #1;
    chk("R10 mem_en in reset", {31'b0, mem_en}, 32'h0);
    chk("R10 align_fault in reset", {31'b0, align_fault}, 32'h0);
    chk("R10 ld_valid in reset", {31'b0, ld_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    req_valid = 0;
    repeat (3) idle();

    // R9: word store and all lane views, both orders
    step(1, 1, 2'd2, 0, 0, 32'h100, 16'h0, 32'h11F2_7384);
    for (int be = 0; be < 2; be++)
      for (int u = 0; u < 2; u++) begin
        for (int o = 0; o < 4; o++) step(1, 0, 2'd0, u[0], be[0], 32'h100, 16'(o), 0);
        for (int o = 0; o < 4; o += 2) step(1, 0, 2'd1, u[0], be[0], 32'h100, 16'(o), 0);
        step(1, 0, 2'd2, u[0], be[0], 32'h100, 16'h0, 0);
      end

    // R7/R8: top bits set in every lane
    step(1, 1, 2'd2, 0, 0, 32'h104, 16'h0, 32'h80FF_F1C0);
    for (int o = 0; o < 4; o++) step(1, 0, 2'd0, 0, 1, 32'h104, 16'(o), 0);
    step(1, 0, 2'd1, 1, 1, 32'h104, 16'h2, 0);
    step(1, 0, 2'd1, 0, 0, 32'h104, 16'h2, 0);

    // R5: narrow stores ignore upper source bits
    step(1, 1, 2'd0, 0, 0, 32'h108, 16'h1, 32'hDEAD_BE85);
    peek(32'h108);
    step(1, 1, 2'd1, 0, 1, 32'h108, 16'h2, 32'hCAFE_A1B2);
    peek(32'h108);
    step(1, 1, 2'd0, 0, 1, 32'h108, 16'h3, 32'hFFFF_FF6E);
    step(1, 0, 2'd0, 1, 0, 32'h108, 16'h0, 0);

    // R2: misaligned requests leave memory untouched
    step(1, 1, 2'd1, 0, 0, 32'h10C, 16'h3, 32'hFFFF_FFFF);
    step(1, 1, 2'd2, 0, 1, 32'h10C, 16'h2, 32'hFFFF_FFFF);
    step(1, 0, 2'd2, 0, 0, 32'h10C, 16'h1, 0);
    peek(32'h10C);

    // R1: negative displacement
    step(1, 1, 2'd2, 0, 0, 32'h200, 16'hFFF8, 32'h0BAD_F00D);
    step(1, 0, 2'd2, 0, 0, 32'h1F0, 16'h0008, 0);
    // R3: size code 3 acts as a word
    step(1, 0, 2'd3, 1, 1, 32'h1F8, 16'h0, 0);
    step(1, 0, 2'd3, 0, 0, 32'h1F9, 16'h0, 0);

    // mixed random traffic
    for (int k = 0; k < 1500; k++) begin
      step($urandom_range(0, 9) != 0, $urandom_range(0, 2) == 0,
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 32'($urandom),
           16'($urandom), 32'($urandom));
    end
    repeat (2) idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule